// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block supervises a software strobe. Software is expected to change the level of the strobe input regularly. Each change, whether low-to-high or high-to-low, restarts a cycle counter. If the counter runs through a full watchdog period with no change, the block raises a one-cycle timeout request toward the reset generator. A strobe parked high is treated the same as one parked low: both are failures.

Two qualifiers gate the counter. The reset-active input comes back from the reset generator. While it is high, the counter is cleared and held, so counting starts again only once reset ends. A "strobe driven" input stands in for the detector that senses a floating strobe pin. While this input is low, the counter is held at zero and no request is produced.

The strobe passes through a synchronizer of `SYNC_STAGES` flops. An edge is found by comparing the synchronized sample with the one taken a cycle earlier. The period length is `PERIOD_CYCLES` clock cycles.

Top module: `edge_watchdog`

## Requirements
- R1: During `rst_n` low, `timeout_o` is 0. After release, with the strobe steady low, driven, and reset-active low, the first `timeout_o` pulse appears at the PERIOD_CYCLES-th rising clock edge after release.
- R2: A low-to-high change of `strobe_i` clears the counter `SYNC_STAGES`+1 rising edges after the change. The next timeout then comes `PERIOD_CYCLES` edges after that clearing edge.
- R3: A high-to-low change of `strobe_i` clears the counter with the same timing as R2.
- R4: A strobe held steady, at either level, causes a timeout `PERIOD_CYCLES` edges after the last clearing edge.
- R5: `timeout_o` is high for exactly one clock cycle per expiry.
- R6: At expiry the counter restarts from zero. While the strobe stays idle and reset-active stays low, timeouts repeat every `PERIOD_CYCLES` cycles.
- R7: While `reset_active_i` is high, the counter is held at zero and `timeout_o` stays 0. After it falls, the next timeout comes `PERIOD_CYCLES` edges later, whatever count had built up before.
- R8: While `strobe_driven_i` is low, `timeout_o` stays 0 and the counter is held at zero, even when the strobe changes. After it rises, a timeout follows `PERIOD_CYCLES` edges later if the strobe stays idle.
- R9: A strobe pulse lasting one clock cycle is detected. Its trailing change clears the counter, so the timeout comes `SYNC_STAGES`+2+`PERIOD_CYCLES` edges after the leading change.
- R10: A strobe that changes more often than once per `PERIOD_CYCLES` cycles never produces a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Asynchronous software strobe |
| strobe_driven_i | input | 1 | High when the strobe pin is actively driven |
| reset_active_i | input | 1 | High while the system reset is asserted |
| timeout_o | output | 1 | One-cycle timeout request |

## Verification
A counter that fails to clear on one edge polarity shows up as a timeout arriving `SYNC_STAGES`+1 cycles earlier than expected. It shows up within one period of the missed change. A counter that freezes instead of clearing under reset-active or a floating strobe shows up as an early timeout right after release. A stretched or repeated request pulse is visible on the cycle after expiry. An off-by-one limit moves every timeout by one edge, so the bench compares the exact index of the first pulse and the number of pulses in each window.

// File: rtl/ewd_pkg.sv
package ewd_pkg;

  // Counter width needed to hold values 0 .. period-1.
  function automatic int ewd_count_bits(input int period);
    int bits;
    bits = $clog2(period);
    if (bits < 1) bits = 1;
    return bits;
  endfunction

  // Terminal count at which the period expires.
  function automatic int ewd_last_count(input int period);
    return period - 1;
  endfunction

  // Rising edges from a strobe change until its timeout.
  function automatic int ewd_edge_latency(input int stages, input int period);
    return stages + 1 + period;
  endfunction

endpackage

// File: rtl/ewd_sync.sv
module ewd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ewd_edge.sv
module ewd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o,
  output logic any_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;
  assign any_o  = rise_o | fall_o;
endmodule

// File: rtl/ewd_timer.sv
module ewd_timer
  import ewd_pkg::*;
#(
  parameter int PERIOD_CYCLES = 16,
  localparam int CW = ewd_count_bits(PERIOD_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic          hold_i,
  input  logic          clear_i,
  output logic [CW-1:0] count_o,
  output logic          expire_o
);
  localparam logic [CW-1:0] LAST = CW'(ewd_last_count(PERIOD_CYCLES));

  logic [CW-1:0] count_q;
  logic          expire_q;
  logic          frozen;
  logic          at_limit;

  assign frozen   = hold_i | ~enable_i;
  assign at_limit = (count_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      expire_q <= 1'b0;
    end else if (frozen || clear_i) begin
      count_q  <= '0;
      expire_q <= 1'b0;
    end else if (at_limit) begin
      count_q  <= '0;
      expire_q <= 1'b1;
    end else begin
      count_q  <= count_q + CW'(1);
      expire_q <= 1'b0;
    end
  end

  assign count_o  = count_q;
  assign expire_o = expire_q;
endmodule

// File: rtl/edge_watchdog.sv
module edge_watchdog
  import ewd_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int PERIOD_CYCLES = 16,
  localparam int CW = ewd_count_bits(PERIOD_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic strobe_driven_i,
  input  logic reset_active_i,
  output logic timeout_o
);
  logic          strobe_sync;
  logic          strobe_rise;
  logic          strobe_fall;
  logic          strobe_edge;
  logic [CW-1:0] wd_count;
  logic          wd_expire;

  ewd_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (strobe_i),
    .sync_o  (strobe_sync)
  );

  ewd_edge edge_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (strobe_sync),
    .rise_o  (strobe_rise),
    .fall_o  (strobe_fall),
    .any_o   (strobe_edge)
  );

  ewd_timer #(.PERIOD_CYCLES(PERIOD_CYCLES)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (strobe_driven_i),
    .hold_i   (reset_active_i),
    .clear_i  (strobe_edge),
    .count_o  (wd_count),
    .expire_o (wd_expire)
  );

  assign timeout_o = wd_expire;
endmodule

// File: rtl/ewd_checker.sv
module ewd_checker
  import ewd_pkg::*;
#(
  parameter int PERIOD_CYCLES = 16,
  localparam int CW = ewd_count_bits(PERIOD_CYCLES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe_driven_i,
  input logic          reset_active_i,
  input logic          timeout_o,
  input logic          rise_w,
  input logic          fall_w,
  input logic          edge_w,
  input logic [CW-1:0] cnt_w
);
  localparam logic [CW-1:0] LAST = CW'(ewd_last_count(PERIOD_CYCLES));

  a_r2_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rise_w |=> (cnt_w == '0));

  a_r3_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fall_w |=> (cnt_w == '0));

  a_r4_expiry_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> ($past(cnt_w) == LAST));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_driven_i && !reset_active_i && !edge_w && cnt_w != LAST)
      |=> (cnt_w == $past(cnt_w) + CW'(1)));

  a_r7_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    reset_active_i |=> (!timeout_o && cnt_w == '0));

  a_r8_quiet_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_driven_i |=> (!timeout_o && cnt_w == '0));
endmodule

bind edge_watchdog ewd_checker #(.PERIOD_CYCLES(PERIOD_CYCLES)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .strobe_driven_i (strobe_driven_i),
  .reset_active_i  (reset_active_i),
  .timeout_o       (timeout_o),
  .rise_w          (strobe_rise),
  .fall_w          (strobe_fall),
  .edge_w          (strobe_edge),
  .cnt_w           (wd_count)
);

// File: tb/edge_watchdog_tb_top.sv
module edge_watchdog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int S = 2;
  localparam int P = 16;
  localparam int LAT_E = S + 1 + P;   // strobe change to timeout
  localparam int LAT_R = P;           // qualifier release to timeout

  typedef struct packed {
    logic        lvl;
    logic        drv;
    logic        ra;
    int unsigned cyc;
    int unsigned first;   // 0 = none expected
    int unsigned npulse;
    int unsigned req;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b0, 40, LAT_R, 2, 4},  // R4 steady low, R6 repeat
    '{1'b1, 1'b1, 1'b0, 30, LAT_E, 1, 2},  // R2 rising change
    '{1'b1, 1'b1, 1'b0, 20, LAT_R, 1, 4},  // R4 steady high
    '{1'b0, 1'b1, 1'b0, 30, LAT_E, 1, 3},  // R3 falling change
    '{1'b0, 1'b0, 1'b0, 40, 0,     0, 8},  // R8 undriven, idle
    '{1'b1, 1'b0, 1'b0, 40, 0,     0, 8},  // R8 undriven, with change
    '{1'b1, 1'b1, 1'b1, 40, 0,     0, 7},  // R7 held in reset
    '{1'b0, 1'b1, 1'b0, 50, LAT_E, 2, 6}   // R3 change, R6 repeat
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe_i = 1'b0;
  logic strobe_driven_i = 1'b1;
  logic reset_active_i = 1'b0;
  logic timeout_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_watchdog #(.SYNC_STAGES(S), .PERIOD_CYCLES(P)) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .strobe_i        (strobe_i),
    .strobe_driven_i (strobe_driven_i),
    .reset_active_i  (reset_active_i),
    .timeout_o       (timeout_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Run n cycles; record index of first pulse and number of high samples.
  task automatic run(input int n, output int first, output int cnt);
    first = 0;
    cnt = 0;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (timeout_o) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
  endtask

  // Clear the timer through reset-active with the strobe level unchanged.
  task automatic settle();
    int f, c;
    strobe_driven_i = 1'b1;
    reset_active_i  = 1'b1;
    run(S + 2, f, c);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int f, c;
    // R1 reset state
    run(3, f, c);
    check("R1", "pulses in reset", c, 0);
    rst_n = 1'b1;
    run(P + 2, f, c);
    check("R1", "first after release", f, LAT_R);

    for (int v = 0; v < NV; v++) begin
      settle();
      strobe_i        = VECS[v].lvl;
      strobe_driven_i = VECS[v].drv;
      reset_active_i  = VECS[v].ra;
      run(int'(VECS[v].cyc), f, c);
      check($sformatf("R%0d", VECS[v].req), $sformatf("vec %0d first", v), f, int'(VECS[v].first));
      check($sformatf("R%0d", VECS[v].req), $sformatf("vec %0d count", v), c, int'(VECS[v].npulse));
    end

    // R5 pulse width: exactly one high cycle
    settle();
    strobe_i = 1'b0;
    reset_active_i = 1'b0;
    run(LAT_R, f, c);
    check("R5", "pulse present", f, LAT_R);
    run(1, f, c);
    check("R5", "pulse ended", c, 0);

    // R9 one-cycle strobe pulse
    settle();
    reset_active_i = 1'b0;
    strobe_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    strobe_i = 1'b0;
    run(P + S + 4, f, c);
    check("R9", "first after short pulse", f, S + 2 + P - 1);

    // R10 regular strobing
    settle();
    reset_active_i = 1'b0;
    c = 0;
    for (int k = 0; k < 10; k++) begin
      int f2, c2;
      strobe_i = ~strobe_i;
      run(10, f2, c2);
      c += c2;
    end
    check("R10", "pulses while strobing", c, 0);

    // R7 mid-count reset discards built-up count
    settle();
    reset_active_i = 1'b0;
    run(10, f, c);
    reset_active_i = 1'b1;
    run(3, f, c);
    check("R7", "pulses during reset", c, 0);
    reset_active_i = 1'b0;
    run(P + 2, f, c);
    check("R7", "first after release", f, LAT_R);

    // R8 re-enable after undriven
    settle();
    reset_active_i = 1'b0;
    strobe_driven_i = 1'b0;
    run(P + 5, f, c);
    check("R8", "pulses undriven", c, 0);
    strobe_driven_i = 1'b1;
    run(P + 2, f, c);
    check("R8", "first after re-enable", f, LAT_R);

    // R1 reset applied mid-run
    strobe_i = 1'b0;
    run(5, f, c);
    rst_n = 1'b0;
    run(2, f, c);
    check("R1", "output low in reset", int'(timeout_o), 0);
    rst_n = 1'b1;
    run(P + 2, f, c);
    check("R1", "first after second release", f, LAT_R);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule